// File: doc/BRIEF.md
# Dirty Victim Writeback Controller

This controller sits on the processor side of a coherent cache and handles a read miss whose victim line is modified. When a miss is accepted, a modified victim is copied into a one-line writeback buffer and its cache tag is invalidated. The controller then sends a read-to-share request to the system, flagged to say that a dirty victim is waiting to be written back. The fill reply decides the tag state of the new line: exclusive grant or shared grant. After the fill, the controller sends the writeback request. The buffer is released only when the system acknowledges that writeback.

While the victim sits in the writeback buffer, it has already left the cache, but another agent may still ask for it with a copyback snoop. A snoop whose address matches the buffer tag is served from the buffer. The controller makes a second copy into a separate copyback buffer and answers with a dirty snoop acknowledgement. The copyback buffer is freed when the system reports the copyback data taken. A snoop that does not match gets a plain acknowledgement and moves no data.

All requests leave on one registered system request port. A snoop answer wins that port over a pending read-to-share or writeback request, which then goes out one cycle later.

Top module: `dvw_ctrl`

## Requirements
- R1: During and straight after reset, `sys_req_valid`, `tag_wr`, `wb_valid` and `cb_valid` are 0, and `miss_ready` and `snp_ready` are 1.
- R2: A miss accepted with `vic_state` = 3 (modified; codes 0 invalid, 1 shared, 2 exclusive, 3 modified) loads the writeback buffer with `vic_addr`/`vic_data` at the accepting edge. For any accepted victim, the next cycle shows `tag_wr`=1, `tag_addr`=`vic_addr`, `tag_state`=0.
- R3: One cycle after acceptance, unless a snoop is accepted in that cycle, the controller issues a request of type 1 (read-to-share) with `sys_req_addr` = miss address. `sys_req_dvp` is 1 exactly when the victim was modified.
- R4: While waiting for the fill, reply type 0 (exclusive grant) or type 1 (shared grant) produces in the next cycle a tag write of the miss address with state 2 or state 1 respectively.
- R5: An accepted snoop whose address equals the valid writeback buffer tag loads the copyback buffer with the writeback buffer's address and data. It yields request type 4 (dirty snoop ack) in the next cycle and leaves the writeback buffer and the tags unchanged.
- R6: An accepted snoop that does not hit the valid writeback buffer yields request type 3 (plain snoop ack) in the next cycle, with no buffer change.
- R7: `snp_ready` is 0 while the copyback buffer is valid. Reply type 2 (copyback data taken) clears it, and nothing else does.
- R8: After a fill with a dirty victim pending, request type 2 (writeback) is issued with the buffer tag as address. The writeback buffer stays valid and unchanged until reply type 3 (writeback acknowledged) arrives while waiting for it.
- R9: `miss_ready` is 1 only when the controller is idle and the writeback buffer is empty. A miss presented while it is 0 is not accepted.
- R10: A snoop accepted in the same cycle that a read-to-share or writeback request is due takes the request port, and the due request is issued one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| miss_valid | input | 1 | Read miss with a victim presented |
| miss_addr | input | AW | Line address of the missed line |
| vic_addr | input | AW | Line address of the victim |
| vic_state | input | 2 | Victim tag state (0 I, 1 S, 2 E, 3 M) |
| vic_data | input | DW | Victim line data |
| miss_ready | output | 1 | Miss can be accepted this cycle |
| sys_rep_valid | input | 1 | System reply present |
| sys_rep_type | input | 2 | 0 fill exclusive, 1 fill shared, 2 copyback taken, 3 writeback ack |
| snp_valid | input | 1 | Copyback snoop present |
| snp_addr | input | AW | Snoop line address |
| snp_ready | output | 1 | Snoop can be accepted this cycle |
| sys_req_valid | output | 1 | Request to system, one-cycle pulse |
| sys_req_type | output | 3 | 1 read-to-share, 2 writeback, 3 snoop ack, 4 dirty snoop ack |
| sys_req_addr | output | AW | Request line address |
| sys_req_dvp | output | 1 | Dirty victim pending flag on read-to-share |
| tag_wr | output | 1 | Tag write strobe |
| tag_addr | output | AW | Tag write address |
| tag_state | output | 2 | Tag state written |
| wb_valid | output | 1 | Writeback buffer holds a line |
| wb_addr | output | AW | Writeback buffer tag |
| wb_data | output | DW | Writeback buffer data |
| cb_valid | output | 1 | Copyback buffer holds a line |
| cb_addr | output | AW | Copyback buffer address |
| cb_data | output | DW | Copyback buffer data |

## Verification
A stale or lost writeback-buffer valid bit shows in one of three ways at the ports, at the latest on the next clock. The controller may accept a second miss while a victim is held, it may send a plain instead of a dirty snoop ack for the held line, or it may send a writeback request with no buffered data. A wrong sequencer state shows as a request of the wrong type, or one cycle early or late on the request port. A tag write with the wrong state code shows in the cycle after the fill reply. The bench compares every output with its own model on every cycle, so any such divergence is reported in the cycle it first appears.

// File: rtl/dvw_pkg.sv
// Shared encodings for the dirty victim writeback controller.
// Assumes all numeric codes below are fixed by the external ports.
package dvw_pkg;

    typedef enum logic [1:0] {
        LN_INV = 2'd0,
        LN_SHR = 2'd1,
        LN_EXC = 2'd2,
        LN_MOD = 2'd3
    } line_st_e;

    typedef enum logic [2:0] {
        RQ_NONE  = 3'd0,
        RQ_RDSH  = 3'd1,
        RQ_WBACK = 3'd2,
        RQ_ACK   = 3'd3,
        RQ_ACKD  = 3'd4
    } sysreq_e;

    typedef enum logic [1:0] {
        RP_FILL_EXC = 2'd0,
        RP_FILL_SHR = 2'd1,
        RP_CB_TAKEN = 2'd2,
        RP_WB_DONE  = 2'd3
    } sysrep_e;

    typedef enum logic [2:0] {
        SQ_IDLE       = 3'd0,
        SQ_SEND_RD    = 3'd1,
        SQ_WAIT_FILL  = 3'd2,
        SQ_SEND_WB    = 3'd3,
        SQ_WAIT_WBACK = 3'd4
    } seq_e;

endpackage

// File: rtl/dvw_linebuf.sv
// One-line holding buffer with a valid bit.
// A load wins over a clear in the same cycle. Clearing drops only the valid bit;
// address and data keep their last value. Assumes callers load only when allowed.
module dvw_linebuf #(
    parameter int AW = 16,
    parameter int DW = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] ld_addr,
    input  logic [DW-1:0] ld_data,
    input  logic          clr,
    output logic          valid,
    output logic [AW-1:0] addr,
    output logic [DW-1:0] data
);

    // Capture a line on load, release it on clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid <= 1'b0;
            addr  <= '0;
            data  <= '0;
        end else if (load) begin
            valid <= 1'b1;
            addr  <= ld_addr;
            data  <= ld_data;
        end else if (clr) begin
            valid <= 1'b0;
        end
    end

endmodule

// File: rtl/dvw_seq.sv
// Miss / writeback sequencer. It accepts a miss, sends the read-to-share, installs
// the fill, then sends the writeback and waits for its acknowledgement.
// All request and tag outputs are registered pulses. A snoop taken in a cycle
// owns the request port, so a due request waits one more cycle.
// Assumes only one miss is in flight at a time.
module dvw_seq
    import dvw_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          miss_valid,
    input  logic [AW-1:0] miss_addr,
    input  logic [AW-1:0] vic_addr,
    input  logic [1:0]    vic_state,
    input  logic          rep_valid,
    input  logic [1:0]    rep_type,
    input  logic          snp_take,
    input  logic          snp_hit,
    input  logic [AW-1:0] snp_addr,
    input  logic          wb_valid,
    input  logic [AW-1:0] wb_addr,
    output logic          miss_ready,
    output logic          wb_load,
    output logic          wb_clr,
    output logic          req_valid,
    output logic [2:0]    req_type,
    output logic [AW-1:0] req_addr,
    output logic          req_dvp,
    output logic          tag_wr,
    output logic [AW-1:0] tag_addr,
    output logic [1:0]    tag_state
);

    seq_e          state, state_nxt;
    logic          dvp_q;
    logic [AW-1:0] miss_q;
    logic          accept, fill, fill_exc, send_rd, send_wb;

    // Decode handshakes and reply events for the current state.
    always_comb begin
        miss_ready = (state == SQ_IDLE) && !wb_valid;                 // R9
        accept     = miss_ready && miss_valid;
        wb_load    = accept && (vic_state == LN_MOD);                  // R2
        fill_exc   = rep_valid && (rep_type == RP_FILL_EXC);
        fill       = (state == SQ_WAIT_FILL) &&
                     (fill_exc || (rep_valid && (rep_type == RP_FILL_SHR)));
        wb_clr     = (state == SQ_WAIT_WBACK) && rep_valid &&
                     (rep_type == RP_WB_DONE);                         // R8
        send_rd    = (state == SQ_SEND_RD) && !snp_take;               // R10
        send_wb    = (state == SQ_SEND_WB) && !snp_take;
    end

    // Next-state selection of the sequencer.
    always_comb begin
        state_nxt = state;
        case (state)
            SQ_IDLE:       if (accept)  state_nxt = SQ_SEND_RD;
            SQ_SEND_RD:    if (send_rd) state_nxt = SQ_WAIT_FILL;
            SQ_WAIT_FILL:  if (fill)    state_nxt = dvp_q ? SQ_SEND_WB : SQ_IDLE;
            SQ_SEND_WB:    if (send_wb) state_nxt = SQ_WAIT_WBACK;
            SQ_WAIT_WBACK: if (wb_clr)  state_nxt = SQ_IDLE;
            default:                    state_nxt = SQ_IDLE;
        endcase
    end

    // State, miss context and registered request/tag outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= SQ_IDLE;
            dvp_q     <= 1'b0;
            miss_q    <= '0;
            req_valid <= 1'b0;
            req_type  <= RQ_NONE;
            req_addr  <= '0;
            req_dvp   <= 1'b0;
            tag_wr    <= 1'b0;
            tag_addr  <= '0;
            tag_state <= LN_INV;
        end else begin
            state     <= state_nxt;
            req_valid <= 1'b0;
            req_type  <= RQ_NONE;
            req_addr  <= '0;
            req_dvp   <= 1'b0;
            tag_wr    <= 1'b0;
            tag_addr  <= '0;
            tag_state <= LN_INV;
            if (accept) begin                                          // R2
                dvp_q     <= (vic_state == LN_MOD);
                miss_q    <= miss_addr;
                tag_wr    <= 1'b1;
                tag_addr  <= vic_addr;
                tag_state <= LN_INV;
            end
            if (fill) begin                                            // R4
                tag_wr    <= 1'b1;
                tag_addr  <= miss_q;
                tag_state <= fill_exc ? LN_EXC : LN_SHR;
            end
            if (snp_take) begin                                        // R5 R6
                req_valid <= 1'b1;
                req_type  <= snp_hit ? RQ_ACKD : RQ_ACK;
                req_addr  <= snp_addr;
            end else if (send_rd) begin                                // R3
                req_valid <= 1'b1;
                req_type  <= RQ_RDSH;
                req_addr  <= miss_q;
                req_dvp   <= dvp_q;
            end else if (send_wb) begin                                // R8
                req_valid <= 1'b1;
                req_type  <= RQ_WBACK;
                req_addr  <= wb_addr;
            end
        end
    end

endmodule

// File: rtl/dvw_ctrl.sv
// Top of the dirty victim writeback controller. It ties the sequencer to the
// writeback buffer and the copyback buffer and decodes snoops against the
// writeback buffer tag. Assumes the cache array itself is looked up elsewhere;
// a snoop here is only compared against the held victim.
module dvw_ctrl
    import dvw_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          miss_valid,
    input  logic [AW-1:0] miss_addr,
    input  logic [AW-1:0] vic_addr,
    input  logic [1:0]    vic_state,
    input  logic [DW-1:0] vic_data,
    output logic          miss_ready,
    input  logic          sys_rep_valid,
    input  logic [1:0]    sys_rep_type,
    input  logic          snp_valid,
    input  logic [AW-1:0] snp_addr,
    output logic          snp_ready,
    output logic          sys_req_valid,
    output logic [2:0]    sys_req_type,
    output logic [AW-1:0] sys_req_addr,
    output logic          sys_req_dvp,
    output logic          tag_wr,
    output logic [AW-1:0] tag_addr,
    output logic [1:0]    tag_state,
    output logic          wb_valid,
    output logic [AW-1:0] wb_addr,
    output logic [DW-1:0] wb_data,
    output logic          cb_valid,
    output logic [AW-1:0] cb_addr,
    output logic [DW-1:0] cb_data
);

    logic wb_load, wb_clr, snp_take, snp_hit, cb_taken;

    // Snoop decode: accept when the copyback buffer is free, hit on the held tag.
    always_comb begin
        snp_ready = !cb_valid;                                         // R7
        snp_take  = snp_valid && snp_ready;
        snp_hit   = snp_take && wb_valid && (snp_addr == wb_addr);     // R5
        cb_taken  = sys_rep_valid && (sys_rep_type == RP_CB_TAKEN);
    end

    dvw_seq #(.AW(AW)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .miss_valid (miss_valid),
        .miss_addr  (miss_addr),
        .vic_addr   (vic_addr),
        .vic_state  (vic_state),
        .rep_valid  (sys_rep_valid),
        .rep_type   (sys_rep_type),
        .snp_take   (snp_take),
        .snp_hit    (snp_hit),
        .snp_addr   (snp_addr),
        .wb_valid   (wb_valid),
        .wb_addr    (wb_addr),
        .miss_ready (miss_ready),
        .wb_load    (wb_load),
        .wb_clr     (wb_clr),
        .req_valid  (sys_req_valid),
        .req_type   (sys_req_type),
        .req_addr   (sys_req_addr),
        .req_dvp    (sys_req_dvp),
        .tag_wr     (tag_wr),
        .tag_addr   (tag_addr),
        .tag_state  (tag_state)
    );

    dvw_linebuf #(.AW(AW), .DW(DW)) u_wbuf (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (wb_load),
        .ld_addr (vic_addr),
        .ld_data (vic_data),
        .clr     (wb_clr),
        .valid   (wb_valid),
        .addr    (wb_addr),
        .data    (wb_data)
    );

    dvw_linebuf #(.AW(AW), .DW(DW)) u_cbuf (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (snp_hit),
        .ld_addr (wb_addr),
        .ld_data (wb_data),
        .clr     (cb_taken),
        .valid   (cb_valid),
        .addr    (cb_addr),
        .data    (cb_data)
    );

endmodule

// File: rtl/dvw_ctrl_chk.sv
// Port-level protocol checker for dvw_ctrl, attached through bind.
// Assumes the reply and snoop codes of dvw_pkg.
module dvw_ctrl_chk #(
    parameter int AW = 16,
    parameter int DW = 64
) (
    input logic          clk,
    input logic          rst_n,
    input logic          miss_valid,
    input logic          miss_ready,
    input logic          sys_rep_valid,
    input logic [1:0]    sys_rep_type,
    input logic          snp_valid,
    input logic [AW-1:0] snp_addr,
    input logic          snp_ready,
    input logic          sys_req_valid,
    input logic [2:0]    sys_req_type,
    input logic          wb_valid,
    input logic [AW-1:0] wb_addr,
    input logic [DW-1:0] wb_data,
    input logic          cb_valid,
    input logic [DW-1:0] cb_data
);

    // After a miss is taken, the controller is busy on the next cycle.
    p_busy_after_accept_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (miss_valid && miss_ready) |=> !miss_ready);

    // The held victim survives until its writeback acknowledgement.
    p_wb_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_valid && !(sys_rep_valid && sys_rep_type == 2'd3))
        |=> (wb_valid && $stable(wb_data) && $stable(wb_addr)));

    // A snoop hitting the held victim gets a second copy and a dirty ack.
    p_cb_copy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_valid && snp_ready && wb_valid && snp_addr == wb_addr)
        |=> (cb_valid && cb_data == $past(wb_data) && sys_req_valid &&
             sys_req_type == 3'd4));

    // A snoop missing the held victim gets a plain ack.
    p_snoop_miss_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_valid && snp_ready && !(wb_valid && snp_addr == wb_addr))
        |=> (sys_req_valid && sys_req_type == 3'd3));

    // The copyback copy stays put until the system takes it.
    p_cb_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cb_valid && !(sys_rep_valid && sys_rep_type == 2'd2))
        |=> (cb_valid && $stable(cb_data)));

    // A taken snoop always owns the request port in the next cycle.
    p_snoop_prio_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_valid && snp_ready)
        |=> (sys_req_valid && (sys_req_type == 3'd3 || sys_req_type == 3'd4)));

endmodule

bind dvw_ctrl dvw_ctrl_chk #(.AW(AW), .DW(DW)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .miss_valid    (miss_valid),
    .miss_ready    (miss_ready),
    .sys_rep_valid (sys_rep_valid),
    .sys_rep_type  (sys_rep_type),
    .snp_valid     (snp_valid),
    .snp_addr      (snp_addr),
    .snp_ready     (snp_ready),
    .sys_req_valid (sys_req_valid),
    .sys_req_type  (sys_req_type),
    .wb_valid      (wb_valid),
    .wb_addr       (wb_addr),
    .wb_data       (wb_data),
    .cb_valid      (cb_valid),
    .cb_data       (cb_data)
);

// File: tb/tb_dvw_ctrl.sv
`timescale 1ns/1ps
// Bench: behavioural reference model updated on each rising edge and compared
// with every output on each falling edge.
module tb_dvw_ctrl;
    localparam int AW = 16;
    localparam int DW = 64;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          miss_valid = 1'b0;
    logic [AW-1:0] miss_addr = '0;
    logic [AW-1:0] vic_addr = '0;
    logic [1:0]    vic_state = 2'd0;
    logic [DW-1:0] vic_data = '0;
    logic          miss_ready;
    logic          sys_rep_valid = 1'b0;
    logic [1:0]    sys_rep_type = 2'd0;
    logic          snp_valid = 1'b0;
    logic [AW-1:0] snp_addr = '0;
    logic          snp_ready;
    logic          sys_req_valid;
    logic [2:0]    sys_req_type;
    logic [AW-1:0] sys_req_addr;
    logic          sys_req_dvp;
    logic          tag_wr;
    logic [AW-1:0] tag_addr;
    logic [1:0]    tag_state;
    logic          wb_valid;
    logic [AW-1:0] wb_addr;
    logic [DW-1:0] wb_data;
    logic          cb_valid;
    logic [AW-1:0] cb_addr;
    logic [DW-1:0] cb_data;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    dvw_ctrl #(.AW(AW), .DW(DW)) dut (.*);

    // Reference model state: 0 idle, 1 send read, 2 wait fill, 3 send writeback, 4 wait ack.
    int            m_st;
    bit            m_wbv, m_cbv, m_dvp, m_rqv, m_rqd, m_tw;
    int            m_rqt, m_ts;
    logic [AW-1:0] m_wba, m_cba, m_ma, m_rqa, m_ta;
    logic [DW-1:0] m_wbd, m_cbd;

    always @(posedge clk) begin : model
        int n_st, n_rqt, n_ts;
        bit n_wbv, n_cbv, n_dvp, n_rqv, n_rqd, n_tw, take, hit;
        logic [AW-1:0] n_wba, n_cba, n_ma, n_rqa, n_ta;
        logic [DW-1:0] n_wbd, n_cbd;
        if (!rst_n) begin
            m_st = 0; m_wbv = 0; m_cbv = 0; m_dvp = 0; m_rqv = 0; m_rqd = 0;
            m_tw = 0; m_rqt = 0; m_ts = 0; m_wba = '0; m_cba = '0; m_ma = '0;
            m_rqa = '0; m_ta = '0; m_wbd = '0; m_cbd = '0;
        end else begin
            n_st = m_st; n_wbv = m_wbv; n_cbv = m_cbv; n_dvp = m_dvp; n_ma = m_ma;
            n_wba = m_wba; n_wbd = m_wbd; n_cba = m_cba; n_cbd = m_cbd;
            n_rqv = 0; n_rqt = 0; n_rqa = '0; n_rqd = 0; n_tw = 0; n_ta = '0; n_ts = 0;
            take = snp_valid && !m_cbv;
            hit  = take && m_wbv && (snp_addr == m_wba);
            if (take) begin n_rqv = 1; n_rqt = hit ? 4 : 3; n_rqa = snp_addr; end
            if (sys_rep_valid && sys_rep_type == 2'd2) n_cbv = 0;
            if (hit) begin n_cbv = 1; n_cba = m_wba; n_cbd = m_wbd; end
            case (m_st)
                0: if (miss_valid && !m_wbv) begin
                       n_tw = 1; n_ta = vic_addr; n_ts = 0; n_ma = miss_addr;
                       n_dvp = (vic_state == 2'd3);
                       if (vic_state == 2'd3) begin n_wbv = 1; n_wba = vic_addr; n_wbd = vic_data; end
                       n_st = 1;
                   end
                1: if (!take) begin n_rqv = 1; n_rqt = 1; n_rqa = m_ma; n_rqd = m_dvp; n_st = 2; end
                2: if (sys_rep_valid && sys_rep_type <= 2'd1) begin
                       n_tw = 1; n_ta = m_ma; n_ts = (sys_rep_type == 2'd0) ? 2 : 1;
                       n_st = m_dvp ? 3 : 0;
                   end
                3: if (!take) begin n_rqv = 1; n_rqt = 2; n_rqa = m_wba; n_st = 4; end
                4: if (sys_rep_valid && sys_rep_type == 2'd3) begin n_wbv = 0; n_st = 0; end
                default: n_st = 0;
            endcase
            m_st = n_st; m_wbv = n_wbv; m_cbv = n_cbv; m_dvp = n_dvp; m_ma = n_ma;
            m_wba = n_wba; m_wbd = n_wbd; m_cba = n_cba; m_cbd = n_cbd;
            m_rqv = n_rqv; m_rqt = n_rqt; m_rqa = n_rqa; m_rqd = n_rqd;
            m_tw = n_tw; m_ta = n_ta; m_ts = n_ts;
        end
    end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // Per-cycle comparison against the model, away from the rising edge.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R9 miss_ready", 64'(miss_ready), 64'(m_st == 0 && !m_wbv));
            chk("R7 snp_ready", 64'(snp_ready), 64'(!m_cbv));
            chk("R3 sys_req_valid", 64'(sys_req_valid), 64'(m_rqv));
            chk("R5 R6 R10 sys_req_type", 64'(sys_req_type), 64'(m_rqt));
            chk("R3 R8 sys_req_addr", 64'(sys_req_addr), 64'(m_rqa));
            chk("R3 sys_req_dvp", 64'(sys_req_dvp), 64'(m_rqd));
            chk("R2 tag_wr", 64'(tag_wr), 64'(m_tw));
            chk("R2 R4 tag_addr", 64'(tag_addr), 64'(m_ta));
            chk("R4 tag_state", 64'(tag_state), 64'(m_ts));
            chk("R8 wb_valid", 64'(wb_valid), 64'(m_wbv));
            chk("R7 cb_valid", 64'(cb_valid), 64'(m_cbv));
            if (m_wbv) begin
                chk("R2 wb_addr", 64'(wb_addr), 64'(m_wba));
                chk("R2 wb_data", 64'(wb_data), 64'(m_wbd));
            end
            if (m_cbv) begin
                chk("R5 cb_addr", 64'(cb_addr), 64'(m_cba));
                chk("R5 cb_data", 64'(cb_data), 64'(m_cbd));
            end
        end
    end

    task automatic step();
        @(negedge clk); #1;
        miss_valid = 1'b0; sys_rep_valid = 1'b0; snp_valid = 1'b0;
    endtask

    task automatic miss(input logic [AW-1:0] ma, input logic [AW-1:0] va,
                        input logic [1:0] vs, input logic [DW-1:0] vd);
        miss_valid = 1'b1; miss_addr = ma; vic_addr = va; vic_state = vs; vic_data = vd;
        step();
    endtask

    task automatic reply(input logic [1:0] t);
        sys_rep_valid = 1'b1; sys_rep_type = t;
        step();
    endtask

    task automatic snoop(input logic [AW-1:0] a);
        snp_valid = 1'b1; snp_addr = a;
        step();
    endtask

    initial begin : stim
        logic [AW-1:0] last_va;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 sys_req_valid", 64'(sys_req_valid), 64'd0);
        chk("R1 tag_wr", 64'(tag_wr), 64'd0);
        chk("R1 wb_valid", 64'(wb_valid), 64'd0);
        chk("R1 cb_valid", 64'(cb_valid), 64'd0);
        chk("R1 miss_ready", 64'(miss_ready), 64'd1);
        chk("R1 snp_ready", 64'(snp_ready), 64'd1);
        #1 rst_n = 1'b1;
        step();
        // Modified victim, exclusive fill, writeback, ack.
        miss(16'h0100, 16'h0200, 2'd3, 64'hA5A5_0000_1111_2222);
        miss(16'h0104, 16'h0204, 2'd3, 64'h1);        // R9: stalled, not taken
        step(); step();
        reply(2'd0);
        step(); step();
        reply(2'd3);
        step();
        // Modified victim; snoop hit in the cycle the read is due (R10, R5).
        miss(16'h0110, 16'h0300, 2'd3, 64'hDEAD_BEEF_0BAD_F00D);
        snoop(16'h0300);
        step();
        snoop(16'h0300);                               // R7: refused while busy
        reply(2'd2);
        reply(2'd3);                                   // R8: ignored outside wait-ack
        reply(2'd1);
        snoop(16'h0300);                               // R10: hit when writeback due
        step();
        reply(2'd2);
        reply(2'd3);
        step();
        // Clean victim: no buffer, flag clear, no writeback.
        miss(16'h0120, 16'h0400, 2'd2, 64'h77);
        step(); step();
        reply(2'd1);
        step();
        snoop(16'h0777);                               // R6: plain ack
        step();
        // Random phase.
        last_va = '0;
        for (int i = 0; i < 3000; i++) begin
            if (($urandom % 4) == 0) begin
                miss_valid = 1'b1;
                miss_addr  = AW'(16'h1000 + ($urandom % 8) * 16);
                vic_addr   = AW'(16'h2000 + ($urandom % 8) * 16);
                vic_state  = 2'($urandom % 4);
                vic_data   = {$urandom, $urandom};
                if (miss_ready) last_va = vic_addr;
            end
            if (($urandom % 3) == 0) begin
                sys_rep_valid = 1'b1;
                sys_rep_type  = 2'($urandom % 4);
            end
            if (($urandom % 5) == 0) begin
                snp_valid = 1'b1;
                snp_addr  = (($urandom % 2) == 0) ? last_va : AW'(16'h2000 + ($urandom % 8) * 16);
            end
            step();
        end
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL R1 watchdog actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule